// File: doc/BRIEF.md
# Low-Power-Aware Interval Timer

This block is a 16-bit down-counting interval timer with a programmable clock divider. Software sets a modulus value and a control word over a small synchronous register port. While enabled, the counter steps down by one on every divided tick. When a tick arrives with the counter at zero, the block raises a sticky expiry flag. The counter then either reloads from the modulus or rolls over to all ones. The flag, gated by an enable bit, forms the interrupt request.

Counting follows the system power state and a debug-halt input. The block counts normally in run and in wait, so the request can wake the system from wait. In doze and under debug halt it counts or stops depending on two separate freeze bits. In stop it always stops. A freeze keeps the counter and the divider exactly as they were, and counting resumes from that point. Register writes made during a freeze still land and take effect once counting restarts.

Top module: `lp_interval_timer`

## Requirements
- R1: After reset, the control word reads 0x0000, the modulus reads 0xFFFF, the counter (address 2) reads 0xFFFF and irqReq is low. Address 0 is the control word, address 1 is the modulus, address 2 is the read-only counter, and address 3 reads zero.
- R2: While enabled (control bit 0 = 1) and not frozen, the counter decreases by one on each divided tick.
- R3: If control bit 1 (reload) is 1, a tick that finds the counter at 0 loads the current modulus value.
- R4: Control bit 2 is the expiry flag. A tick at count 0 sets it. Writing the control word with bit 2 = 1 clears it, and writing 0 there leaves it unchanged. If an expiry and a clear happen in the same cycle, the set wins.
- R5: If the reload bit is 0, a tick at count 0 rolls the counter over to 0xFFFF.
- R6: irqReq equals the expiry flag ANDed with control bit 3 (interrupt enable).
- R7: Control bits 11:8 hold a value N. A tick occurs once every 2^N unfrozen enabled cycles, and the divider starts from zero whenever the timer is disabled.
- R8: pwrState takes the values 0 run, 1 wait, 2 doze and 3 stop. Run and wait count identically. In doze, counting continues if control bit 6 is 0 and freezes if it is 1.
- R9: While dbgHalt is high, counter and divider freeze if control bit 5 is 1 and are unaffected if it is 0. After a freeze, counting resumes from the held values with no reload.
- R10: Register writes made while frozen are kept, and they apply when counting resumes.
- R11: In stop (pwrState = 3), counter and divider hold regardless of the freeze bits.
- R12: If control bit 4 (overwrite) is 1, a modulus write also loads the counter in the next cycle and restarts the divider. If it is 0, only the modulus changes.
- R13: While control bit 0 is 0, the counter is held at the modulus value and no tick occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrState | input | 2 | System power state: 0 run, 1 wait, 2 doze, 3 stop |
| dbgHalt | input | 1 | Debug halt request |
| busWr | input | 1 | Write strobe for the register port |
| busAddr | input | 2 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr (combinational) |
| irqReq | output | 1 | Interrupt request |

## Verification
On every cycle, the embedded assertions check the following: the one-step decrement, reload and roll-over at zero, holding when no tick or load is present, presetting while disabled, and overwrite loading in the counter path. In the control path they check flag set and clear priority and the divider holding in stop. Other behaviours need the bench's scenarios, which compare every cycle against a behavioural model. These are the divide ratio for a given N, the correct choice of freeze bit for each power state, resumption from the exact held value, and writes made during a debug freeze that only show up at a later reload.

// File: rtl/lpt_pkg.sv
`timescale 1ns/1ps
package lpt_pkg;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_WAIT = 2'd1,
    PWR_DOZE = 2'd2,
    PWR_STOP = 2'd3
  } pwrState_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MOD  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;

  localparam int BIT_EN    = 0;
  localparam int BIT_RLD   = 1;
  localparam int BIT_FLAG  = 2;
  localparam int BIT_IE    = 3;
  localparam int BIT_OVW   = 4;
  localparam int BIT_DBGF  = 5;
  localparam int BIT_DOZEF = 6;
  localparam int BIT_PSC   = 8;

  typedef struct packed {
    logic tick;
    logic preset;
    logic modWrite;
    logic overwrite;
    logic reload;
  } dpStrobe_t;

endpackage

// File: rtl/lpt_datapath.sv
`timescale 1ns/1ps
module lpt_datapath
  import lpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cntRd,
  output logic [CNT_W-1:0] modRd,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ZERO     = {CNT_W{1'b0}};

  logic [CNT_W-1:0] cntReg;
  logic [CNT_W-1:0] modReg;
  logic             directLoad;
  logic             atZero;

  always_comb begin
    atZero     = (cntReg == ZERO);
    directLoad = stb.modWrite && stb.overwrite;
    expire     = stb.tick && atZero;
    cntRd      = cntReg;
    modRd      = modReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modReg <= ALL_ONES;
    end else if (stb.modWrite) begin
      modReg <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntReg <= ALL_ONES;
    end else if (stb.preset) begin
      cntReg <= modReg;
    end else if (directLoad) begin
      cntReg <= wdata;
    end else if (stb.tick) begin
      if (atZero) cntReg <= stb.reload ? modReg : ALL_ONES;
      else        cntReg <= cntReg - 1'b1;
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tick && !stb.preset && !directLoad && cntReg != ZERO)
      |=> cntReg == $past(cntReg) - 1'b1);

  p_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tick && !stb.preset && !directLoad && cntReg == ZERO && stb.reload)
      |=> cntReg == $past(modReg));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tick && !stb.preset && !directLoad && cntReg == ZERO && !stb.reload)
      |=> cntReg == ALL_ONES);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.tick && !stb.preset && !directLoad) |=> $stable(cntReg));

  p_overwrite_r12: assert property (@(posedge clk) disable iff (!rstN)
    (directLoad && !stb.preset) |=> cntReg == $past(wdata));

  p_preset_r13: assert property (@(posedge clk) disable iff (!rstN)
    stb.preset |=> cntReg == $past(modReg));

endmodule

// File: rtl/lpt_ctrl.sv
`timescale 1ns/1ps
module lpt_ctrl
  import lpt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        pwrState,
  input  logic              dbgHalt,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              expire,
  input  logic [DATA_W-1:0] cntRd,
  input  logic [DATA_W-1:0] modRd,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqReq,
  output dpStrobe_t         stb
);

  localparam int DIV_W = (1 << PSC_W) - 1;

  logic             enBit, rldBit, ieBit, ovwBit, dbgFrz, dozeFrz, flag;
  logic [PSC_W-1:0] pscSel;
  logic [DIV_W-1:0] presc;
  logic [DIV_W:0]   maskFull;
  logic [DIV_W-1:0] mask;
  logic             frozen, active, tick, ctrlWr, modWr, restart;
  logic [DATA_W-1:0] ctrlRd;
  pwrState_e        pState;

  always_comb begin
    pState   = pwrState_e'(pwrState);
    frozen   = (pState == PWR_STOP)
            || (pState == PWR_DOZE && dozeFrz)
            || (dbgHalt && dbgFrz);
    active   = enBit && !frozen;
    maskFull = ({{DIV_W{1'b0}}, 1'b1} << pscSel) - 1'b1;
    mask     = maskFull[DIV_W-1:0];
    tick     = active && ((presc & mask) == mask);
    ctrlWr   = busWr && (busAddr == ADDR_CTRL);
    modWr    = busWr && (busAddr == ADDR_MOD);
    restart  = modWr && ovwBit;

    stb.tick      = tick;
    stb.preset    = !enBit;
    stb.modWrite  = modWr;
    stb.overwrite = ovwBit;
    stb.reload    = rldBit;

    ctrlRd = '0;
    ctrlRd[BIT_EN]    = enBit;
    ctrlRd[BIT_RLD]   = rldBit;
    ctrlRd[BIT_FLAG]  = flag;
    ctrlRd[BIT_IE]    = ieBit;
    ctrlRd[BIT_OVW]   = ovwBit;
    ctrlRd[BIT_DBGF]  = dbgFrz;
    ctrlRd[BIT_DOZEF] = dozeFrz;
    ctrlRd[BIT_PSC +: PSC_W] = pscSel;

    case (busAddr)
      ADDR_CTRL: busRdata = ctrlRd;
      ADDR_MOD:  busRdata = modRd;
      ADDR_CNT:  busRdata = cntRd;
      default:   busRdata = '0;
    endcase

    irqReq = flag && ieBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit   <= 1'b0;
      rldBit  <= 1'b0;
      ieBit   <= 1'b0;
      ovwBit  <= 1'b0;
      dbgFrz  <= 1'b0;
      dozeFrz <= 1'b0;
      pscSel  <= '0;
    end else if (ctrlWr) begin
      enBit   <= busWdata[BIT_EN];
      rldBit  <= busWdata[BIT_RLD];
      ieBit   <= busWdata[BIT_IE];
      ovwBit  <= busWdata[BIT_OVW];
      dbgFrz  <= busWdata[BIT_DBGF];
      dozeFrz <= busWdata[BIT_DOZEF];
      pscSel  <= busWdata[BIT_PSC +: PSC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          flag <= 1'b0;
    else if (expire)                    flag <= 1'b1;
    else if (ctrlWr && busWdata[BIT_FLAG]) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  presc <= '0;
    else if (!enBit || restart) presc <= '0;
    else if (active)            presc <= tick ? '0 : presc + 1'b1;
  end

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> flag);

  p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busWdata[BIT_FLAG] && !expire) |=> !flag);

  p_stop_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PWR_STOP && enBit && !modWr) |=> $stable(presc));

  p_disabled_div_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!enBit) |=> presc == '0);

endmodule

// File: rtl/lp_interval_timer.sv
`timescale 1ns/1ps
module lp_interval_timer
  import lpt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        pwrState,
  input  logic              dbgHalt,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqReq
);

  dpStrobe_t         stb;
  logic              expire;
  logic [DATA_W-1:0] cntRd;
  logic [DATA_W-1:0] modRd;

  lpt_ctrl #(.DATA_W(DATA_W), .PSC_W(PSC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrState(pwrState), .dbgHalt(dbgHalt),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .expire(expire), .cntRd(cntRd), .modRd(modRd),
    .busRdata(busRdata), .irqReq(irqReq), .stb(stb)
  );

  lpt_datapath #(.CNT_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata),
    .cntRd(cntRd), .modRd(modRd), .expire(expire)
  );

endmodule

// File: tb/test_lp_interval_timer.sv
`timescale 1ns/1ps
module test_lp_interval_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  pwrState = 2'd0;
  logic        dbgHalt = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = 2'd2;
  logic [15:0] busWdata = 16'h0;
  logic [15:0] busRdata;
  logic        irqReq;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  lp_interval_timer i_lp_interval_timer (
    .clk(clk), .rstN(rstN), .pwrState(pwrState), .dbgHalt(dbgHalt),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqReq(irqReq)
  );

  localparam logic [15:0] C_EN = 16'h0001, C_RLD = 16'h0002, C_FLG = 16'h0004,
                          C_IE = 16'h0008, C_OVW = 16'h0010, C_DBG = 16'h0020,
                          C_DOZ = 16'h0040;

  // behavioural reference
  logic mEn, mRld, mIe, mOvw, mDbg, mDoze, mFlag;
  logic [3:0]  mPsc;
  logic [15:0] mMod, mCnt;
  int mPre;

  function automatic logic [15:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0: return {4'h0, mPsc, 1'b0, mDoze, mDbg, mOvw, mIe, mFlag, mRld, mEn};
      2'd1: return mMod;
      2'd2: return mCnt;
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      {mEn, mRld, mIe, mOvw, mDbg, mDoze, mFlag} = '0;
      mPsc = 0; mMod = 16'hFFFF; mCnt = 16'hFFFF; mPre = 0;
    end else begin
      bit frz, act, tk, ex, modW, ctlW, dload;
      logic [15:0] nCnt;
      int nPre;
      frz   = (pwrState == 2'd3) || (pwrState == 2'd2 && mDoze) || (dbgHalt && mDbg);
      act   = mEn && !frz;
      tk    = act && (mPre == (1 << mPsc) - 1);
      ex    = tk && (mCnt == 0);
      modW  = busWr && busAddr == 2'd1;
      ctlW  = busWr && busAddr == 2'd0;
      dload = modW && mOvw;
      if (!mEn) nCnt = mMod;
      else if (dload) nCnt = busWdata;
      else if (tk) nCnt = (mCnt == 0) ? (mRld ? mMod : 16'hFFFF) : mCnt - 16'd1;
      else nCnt = mCnt;
      if (!mEn || dload) nPre = 0;
      else if (act) nPre = tk ? 0 : mPre + 1;
      else nPre = mPre;
      if (ex) mFlag = 1'b1;
      else if (ctlW && busWdata[2]) mFlag = 1'b0;
      if (ctlW) begin
        mEn = busWdata[0]; mRld = busWdata[1]; mIe = busWdata[3]; mOvw = busWdata[4];
        mDbg = busWdata[5]; mDoze = busWdata[6]; mPsc = busWdata[11:8];
      end
      if (modW) mMod = busWdata;
      mCnt = nCnt; mPre = nPre;
    end
    #1;
    if (rstN) begin
      check({curReq, " read"}, busRdata, modelRead(busAddr));
      check({curReq, " irq R6"}, {15'b0, irqReq}, {15'b0, mFlag && mIe});
    end
  end

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0; busAddr = 2'd2;
  endtask

  task automatic setCtrl(input logic [15:0] d);
    wrReg(2'd0, 16'h0);
    wrReg(2'd0, d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); busAddr = a; #0.5; v = busRdata; busAddr = 2'd2;
  endtask

  task automatic chkRead(input string req, input logic [1:0] a, input logic [15:0] exp);
    logic [15:0] v;
    readReg(a, v);
    check(req, v, exp);
  endtask

  task automatic holdCheck(input string req);
    logic [15:0] a, b;
    readReg(2'd2, a);
    idle(12);
    readReg(2'd2, b);
    check(req, b, a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    idle(3);
    rstN = 1'b1;
    curReq = "R1";
    chkRead("R1 ctrl", 2'd0, 16'h0000);
    chkRead("R1 modulus", 2'd1, 16'hFFFF);
    chkRead("R1 count", 2'd2, 16'hFFFF);
    chkRead("R1 addr3", 2'd3, 16'h0000);
    check("R1 irq", {15'b0, irqReq}, 16'h0);

    curReq = "R2_R3";
    wrReg(2'd1, 16'd5);
    wrReg(2'd0, C_EN | C_RLD | C_IE);
    idle(20);
    check("R3 irq after reload expiry", {15'b0, irqReq}, 16'h1);

    curReq = "R4";
    wrReg(2'd0, C_EN | C_RLD | C_IE);
    idle(1);
    wrReg(2'd0, C_EN | C_RLD | C_IE | C_FLG);
    idle(14);

    curReq = "R5";
    setCtrl(16'h0);
    wrReg(2'd1, 16'd3);
    wrReg(2'd0, C_EN | C_IE);
    idle(10);
    readReg(2'd2, v);
    check("R5 wrapped high", {15'b0, v > 16'hFFF0}, 16'h1);

    curReq = "R7";
    setCtrl(C_EN | C_RLD | (16'd2 << 8));
    idle(40);
    setCtrl(C_EN | C_RLD | (16'd1 << 8));
    idle(20);

    curReq = "R8";
    setCtrl(C_EN | C_RLD);
    pwrState = 2'd1; idle(10);
    pwrState = 2'd2; idle(10);
    setCtrl(C_EN | C_RLD | C_DOZ);
    pwrState = 2'd2;
    holdCheck("R8 doze freeze");
    pwrState = 2'd0; idle(6);

    curReq = "R9";
    setCtrl(C_EN | C_RLD | C_DBG | (16'd1 << 8));
    idle(3);
    dbgHalt = 1'b1;
    holdCheck("R9 debug freeze");
    curReq = "R10";
    wrReg(2'd1, 16'd9);
    chkRead("R10 modulus kept in halt", 2'd1, 16'd9);
    dbgHalt = 1'b0;
    idle(30);
    setCtrl(C_EN | C_RLD);
    curReq = "R9";
    dbgHalt = 1'b1; idle(10); dbgHalt = 1'b0;

    curReq = "R11";
    pwrState = 2'd3;
    holdCheck("R11 stop freeze");
    pwrState = 2'd0; idle(4);

    curReq = "R12";
    setCtrl(C_EN | C_RLD | C_OVW);
    wrReg(2'd1, 16'h0020);
    chkRead("R12 overwrite load", 2'd2, 16'h001F);
    setCtrl(C_EN | C_RLD);
    wrReg(2'd1, 16'h0030);
    chkRead("R12 no overwrite", 2'd1, 16'h0030);
    idle(8);

    curReq = "R13";
    wrReg(2'd0, C_RLD);
    chkRead("R13 preset", 2'd2, 16'h0030);
    idle(5);
    chkRead("R13 held", 2'd2, 16'h0030);

    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule